// File: doc/BRIEF.md
# SPI Status Flag Controller

This block is a bus-mapped serial peripheral core built around its status flags. A processor reaches three registers through a plain address/strobe bus: a control register (interrupt enable, master select, slave-select output enable), a read-only status register and a data register. Writing the data register while the core is master and idle starts an 8-bit transfer. The transfer runs on an internal shift engine that drives the serial clock from a fixed divider.

Three flags report what happened: transfer complete, write collision and mode fault. None of them clears on a single access. Software must first read the status register while the flag is set. It then makes a second access that depends on the flag: any data register access for the transfer and collision flags, or a control register write for the mode fault. Only the transfer-complete flag can raise the interrupt output.

The bus accepts one access per cycle with no stall, so the block applies no back-pressure. Read data is valid in the same cycle as the read strobe. A read or write strobe acts on exactly one register. The slave-select direction is a plain input pin, and the slave-select line is read through its own input.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset, the control and status registers read 0x00, and irq, sclk and mosi's clock idle low (sclk = 0).
- R2: A data write (address 2) while the master bit (control bit 4) is 1 and no transfer is running starts a transfer. The transfer has 8 sclk periods, each sclk level lasts SCLK_HALF cycles, mosi carries the byte MSB first, and miso is captured on each rising sclk. The received byte reads back at address 2. A data write with the master bit 0 starts nothing.
- R3: The transfer-complete flag (status bit 7) sets on the clock edge that ends the eighth sclk period, 16*SCLK_HALF cycles after the starting write.
- R4: irq equals transfer-complete AND interrupt enable (control bit 7).
- R5: The transfer-complete flag clears only through a status read (address 1) that sees it set, followed by a data register read or write. A data access without that prior read leaves it set.
- R6: A data write while a transfer runs sets the write-collision flag (status bit 6). The running byte is not altered and the written byte is discarded. The collision flag never drives irq.
- R7: The write-collision flag clears through a status read that sees it set, followed by a data read or write.
- R8: The mode-fault flag (status bit 4) sets when ss_n_in is low while the core is master and ss_dir is 0. On that fault the master bit clears and any running transfer stops, with sclk returning to 0.
- R9: While ss_dir is 1, ss_n_in low never sets the mode-fault flag, whatever the value of the output-enable bit (control bit 1).
- R10: The mode-fault flag clears only through a status read that sees it set, followed by a control write (address 0). Data accesses do not clear it.
- R11: Status bits 5, 3, 2, 1 and 0 read 0, and writes to the status address change nothing.
- R12: A status read that sees a flag clear does not arm that flag's clear. A flag that sets after such a read survives the following clearing access.
- R13: If a flag's set event lands in the same cycle as its clearing access, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, else 0 |
| ss_dir | input | 1 | Slave-select pin direction: 1 output, 0 input |
| ss_n_in | input | 1 | Slave-select pin level as seen by the core |
| ss_n_out | output | 1 | Slave-select drive: low during a transfer when master, ss_dir and output enable are all 1 |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out, MSB first |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several flag behaviours. A flag holds while its clearing access is absent. A finished byte always raises the transfer-complete flag. A collision write always raises its flag. A fault always drops master mode and stops the clock. An input-configured-as-output pin never yields a fault. The bench's scenarios are what show the ordered clear sequences. They also show the stale-read case, a set landing on the clearing cycle, the discarded collision byte, and the received data value, all against a cycle-accurate reference model.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;
  // control register bit positions
  localparam int CB_IEN  = 7;
  localparam int CB_MST  = 4;
  localparam int CB_SSOE = 1;
  // status register bit positions
  localparam int SB_DONE = 7;
  localparam int SB_COLL = 6;
  localparam int SB_FLT  = 4;
  // flag indices inside the core
  localparam int FL_DONE = 0;
  localparam int FL_COLL = 1;
  localparam int FL_FLT  = 2;
  localparam int NFLAG   = 3;
endpackage

// File: rtl/spi_flag_bit.sv
// One sticky status flag with a two-step clear: a status read that sees
// the flag set arms it, a later clearing access then drops it.
module spi_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic stat_rd,
  input  logic clr_acc,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (stat_rd)      armed <= flag;   // arms only if flag seen set
      else if (clr_acc) armed <= 1'b0;   // any clearing access disarms
      if (set_evt)                flag <= 1'b1;  // event wins (R13)
      else if (clr_acc && armed)  flag <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
// Byte shifter: sclk idle low, capture on rising, shift on falling.
module spi_shift_engine #(
  parameter int BITS     = 8,
  parameter int HALF_DIV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic [BITS-1:0] tx_byte,
  input  logic            miso,
  output logic            busy,
  output logic            sclk,
  output logic            mosi,
  output logic            done,
  output logic [BITS-1:0] rx_byte
);
  localparam int EDGES = 2 * BITS;
  localparam int DW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EW    = $clog2(EDGES);

  logic [DW-1:0]   div_q;
  logic [EW-1:0]   edge_q;
  logic [BITS-1:0] sr_q;
  logic            tick;

  assign tick = busy && (div_q == DW'(HALF_DIV - 1));
  assign done = tick && (edge_q == EW'(EDGES - 1)) && !abort;
  assign mosi = sr_q[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      div_q   <= '0;
      edge_q  <= '0;
      sr_q    <= '0;
      rx_byte <= '0;
    end else if (abort) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      sclk   <= 1'b0;
      sr_q   <= tx_byte;
      div_q  <= '0;
      edge_q <= '0;
    end else if (busy) begin
      if (tick) begin
        div_q  <= '0;
        sclk   <= ~sclk;
        edge_q <= edge_q + 1'b1;
        if (!sclk) rx_byte <= {rx_byte[BITS-2:0], miso};
        else       sr_q    <= {sr_q[BITS-2:0], 1'b0};
        if (edge_q == EW'(EDGES - 1)) busy <= 1'b0;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ss_dir,
  input  logic       ss_n_in,
  output logic       ss_n_out,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       irq
);
  logic ien_q, mst_q, ssoe_q;
  logic ctrl_wr_s, stat_rd_s, data_wr_s, data_acc_s;
  logic fault_s, start_s, busy_s, done_s;
  logic [7:0] rx_byte;
  logic [NFLAG-1:0] set_v, clr_v, flag_v;

  assign ctrl_wr_s  = bus_wr && (bus_addr == ADR_CTRL);
  assign stat_rd_s  = bus_rd && (bus_addr == ADR_STAT);
  assign data_wr_s  = bus_wr && (bus_addr == ADR_DATA);
  assign data_acc_s = (bus_rd || bus_wr) && (bus_addr == ADR_DATA);

  // fault only when master and the pin is an input
  assign fault_s = mst_q && !ss_dir && !ss_n_in;
  assign start_s = data_wr_s && mst_q && !busy_s && !fault_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      mst_q  <= 1'b0;
      ssoe_q <= 1'b0;
    end else begin
      if (ctrl_wr_s) begin
        ien_q  <= bus_wdata[CB_IEN];
        mst_q  <= bus_wdata[CB_MST];
        ssoe_q <= bus_wdata[CB_SSOE];
      end
      if (fault_s) mst_q <= 1'b0;
    end
  end

  spi_shift_engine #(.BITS(8), .HALF_DIV(SCLK_HALF)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_s),
    .abort   (fault_s),
    .tx_byte (bus_wdata),
    .miso    (miso),
    .busy    (busy_s),
    .sclk    (sclk),
    .mosi    (mosi),
    .done    (done_s),
    .rx_byte (rx_byte)
  );

  assign set_v[FL_DONE] = done_s;
  assign set_v[FL_COLL] = data_wr_s && busy_s;
  assign set_v[FL_FLT]  = fault_s;
  assign clr_v[FL_DONE] = data_acc_s;
  assign clr_v[FL_COLL] = data_acc_s;
  assign clr_v[FL_FLT]  = ctrl_wr_s;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    spi_flag_bit u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_v[g]),
      .stat_rd (stat_rd_s),
      .clr_acc (clr_v[g]),
      .flag    (flag_v[g])
    );
  end

  assign irq      = flag_v[FL_DONE] && ien_q;
  assign ss_n_out = !(mst_q && ss_dir && ssoe_q && busy_s);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADR_CTRL: begin
          bus_rdata[CB_IEN]  = ien_q;
          bus_rdata[CB_MST]  = mst_q;
          bus_rdata[CB_SSOE] = ssoe_q;
        end
        ADR_STAT: begin
          bus_rdata[SB_DONE] = flag_v[FL_DONE];
          bus_rdata[SB_COLL] = flag_v[FL_COLL];
          bus_rdata[SB_FLT]  = flag_v[FL_FLT];
        end
        ADR_DATA: bus_rdata = rx_byte;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic data_wr,
  input logic data_acc,
  input logic ctrl_wr,
  input logic ss_dir,
  input logic sclk,
  input logic busy,
  input logic done,
  input logic fault,
  input logic spif,
  input logic wcol,
  input logic modf,
  input logic master,
  input logic irq
);
  assert_idle_sclk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> spif);
  assert_irq_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> spif);
  assert_spif_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spif && !data_acc) |=> spif);
  assert_coll_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> wcol);
  assert_coll_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !spif) |-> !irq);
  assert_fault_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (modf && !master && !busy && !sclk));
  assert_dir_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_dir && !modf) |=> !modf);
  assert_modf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (modf && !ctrl_wr) |=> modf);
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .data_wr  (data_wr_s),
  .data_acc (data_acc_s),
  .ctrl_wr  (ctrl_wr_s),
  .ss_dir   (ss_dir),
  .sclk     (sclk),
  .busy     (busy_s),
  .done     (done_s),
  .fault    (fault_s),
  .spif     (flag_v[0]),
  .wcol     (flag_v[1]),
  .modf     (flag_v[2]),
  .master   (mst_q),
  .irq      (irq)
);

// File: tb/spi_flag_ctrl_test.sv
`timescale 1ns/1ps
module spi_flag_ctrl_test;
  localparam int HALF = 2;
  localparam int XFER = 16 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic ss_dir = 1'b0, ss_n_in = 1'b1, ss_n_out, sclk, mosi, irq;
  logic loop = 1'b1;
  logic miso;
  int checks = 0, errors = 0;

  assign miso = loop ? mosi : 1'b1;
  always #4 clk = ~clk;

  spi_flag_ctrl #(.SCLK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_dir(ss_dir), .ss_n_in(ss_n_in), .ss_n_out(ss_n_out),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq));

  // ---------------- reference model ----------------
  bit m_busy, m_spif, m_wcol, m_modf, m_ien, m_mst, m_oe;
  bit arm_spif, arm_wcol, arm_modf;
  int m_t;
  logic [7:0] m_rx, m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_spif = 0; m_wcol = 0; m_modf = 0;
      m_ien = 0; m_mst = 0; m_oe = 0; m_t = 0; m_rx = 0; m_pend = 0;
      arm_spif = 0; arm_wcol = 0; arm_modf = 0;
    end else begin
      bit cw, sr, dw, da, flt, fin, coll;
      cw   = bus_wr && bus_addr == 2'd0;
      sr   = bus_rd && bus_addr == 2'd1;
      dw   = bus_wr && bus_addr == 2'd2;
      da   = (bus_rd || bus_wr) && bus_addr == 2'd2;
      flt  = m_mst && !ss_dir && !ss_n_in;
      fin  = m_busy && !flt && (m_t + 1 == XFER);
      coll = dw && m_busy;
      // transfer progress
      if (flt) begin m_busy = 0; m_t = 0; end
      else if (m_busy) begin
        m_t++;
        if (m_t == XFER) begin m_busy = 0; m_rx = m_pend; end
      end else if (dw && m_mst) begin
        m_busy = 1; m_t = 0; m_pend = loop ? bus_wdata : 8'hFF;
      end
      // transfer-complete flag
      if (fin) m_spif = 1; else if (da && arm_spif) m_spif = 0;
      // collision flag
      if (coll) m_wcol = 1; else if (da && arm_wcol) m_wcol = 0;
      // fault flag
      if (flt) m_modf = 1; else if (cw && arm_modf) m_modf = 0;
      // arming uses the flag values seen before this edge
      if (sr) begin
        arm_spif = uut_seen_spif; arm_wcol = uut_seen_wcol; arm_modf = uut_seen_modf;
      end else begin
        if (da) begin arm_spif = 0; arm_wcol = 0; end
        if (cw) arm_modf = 0;
      end
      if (cw) begin m_ien = bus_wdata[7]; m_mst = bus_wdata[4]; m_oe = bus_wdata[1]; end
      if (flt) m_mst = 0;
    end
  end

  // flag values the model showed during the cycle (before the edge)
  bit uut_seen_spif, uut_seen_wcol, uut_seen_modf;
  always @(negedge clk) begin
    uut_seen_spif = m_spif; uut_seen_wcol = m_wcol; uut_seen_modf = m_modf;
  end

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {m_ien, 2'b00, m_mst, 2'b00, m_oe, 1'b0};
      2'd1: return {m_spif, m_wcol, 1'b0, m_modf, 4'b0000};
      2'd2: return m_rx;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // per-cycle comparison of free-running outputs
  always begin
    @(negedge clk); #3;
    if (rst_n) begin
      check("R2/R8 sclk", {7'd0, sclk}, {7'd0, m_busy ? 1'((m_t / HALF) % 2) : 1'b0});
      check("R4 irq", {7'd0, irq}, {7'd0, m_spif && m_ien});
      check("R2 ss_n_out", {7'd0, ss_n_out}, {7'd0, !(m_mst && ss_dir && m_oe && m_busy)});
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input string req);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #2 check(req, bus_rdata, model_read(a));
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string req);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #2 check(req, bus_rdata, e);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_exp(2'd1, 8'h00, "R1 status");
    rd_exp(2'd0, 8'h00, "R1 ctrl");
    // R2 not master: data write starts nothing
    wr_reg(2'd2, 8'h81); idle(XFER + 4);
    rd_exp(2'd1, 8'h00, "R2 no transfer when not master");
    // R2/R3/R4 basic transfer
    wr_reg(2'd0, 8'h90);
    wr_reg(2'd2, 8'hA5); idle(XFER + 2);
    rd_exp(2'd2, 8'hA5, "R2 loopback data");
    rd_exp(2'd1, 8'h80, "R5 spif kept without status read");
    rd_reg(2'd2, "R5 data read");
    rd_exp(2'd1, 8'h00, "R5 spif cleared");
    // R6/R13/R7 collision
    wr_reg(2'd2, 8'h3C); idle(3);
    wr_reg(2'd2, 8'hFF);
    rd_exp(2'd1, 8'h40, "R6 wcol set");
    wr_reg(2'd2, 8'h77);
    rd_exp(2'd1, 8'h40, "R13 set beats clear");
    check("R6 no irq from wcol", {7'd0, irq}, 8'h00);
    idle(XFER + 2);
    rd_exp(2'd2, 8'h3C, "R6 byte unchanged");
    rd_exp(2'd1, 8'h80, "R7 wcol cleared, spif unarmed");
    rd_reg(2'd2, "R7 data read");
    rd_exp(2'd1, 8'h00, "R7 both clear");
    // R2 miso capture with miso held high
    loop = 1'b0;
    wr_reg(2'd2, 8'h12); idle(XFER + 2);
    rd_exp(2'd2, 8'hFF, "R2 miso capture");
    loop = 1'b1;
    // R12 stale read
    rd_exp(2'd1, 8'h80, "R12 status");
    rd_reg(2'd2, "R12 clear");
    rd_exp(2'd1, 8'h00, "R12 status clear");
    wr_reg(2'd2, 8'h5A); idle(XFER + 2);
    rd_reg(2'd2, "R12 data read");
    rd_exp(2'd1, 8'h80, "R12 flag survives stale read");
    rd_reg(2'd2, "R12 final clear");
    // R8 mode fault aborts a transfer
    wr_reg(2'd2, 8'hC3); idle(5);
    @(negedge clk); ss_n_in = 1'b0;
    @(negedge clk); ss_n_in = 1'b1;
    rd_exp(2'd0, 8'h80, "R8 master dropped");
    rd_exp(2'd1, 8'h10, "R8 modf set");
    wr_reg(2'd2, 8'h00);
    rd_exp(2'd1, 8'h10, "R10 data access keeps modf");
    wr_reg(2'd0, 8'h90);
    rd_exp(2'd1, 8'h00, "R10 modf cleared");
    // R9 output-configured pin
    ss_dir = 1'b1; ss_n_in = 1'b0; idle(4);
    rd_exp(2'd1, 8'h00, "R9 oe=0");
    wr_reg(2'd0, 8'h92); idle(4);
    rd_exp(2'd1, 8'h00, "R9 oe=1");
    ss_n_in = 1'b1;
    wr_reg(2'd2, 8'h66); idle(XFER + 2);
    rd_exp(2'd2, 8'h66, "R9 transfer with ss output");
    ss_dir = 1'b0;
    // R11 status write ignored
    wr_reg(2'd1, 8'hFF);
    rd_exp(2'd1, 8'h80, "R11 status write ignored");
    rd_exp(2'd0, 8'h92, "R11 ctrl unchanged");
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule